// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block arbitrates a single hand-over of the PCI bus to a south-bridge agent. The agent pulls an active-low hold request. The controller does not answer at once. First it stops the CPU from placing new writes into the CPU-to-PCI posted write buffer, and it asks that buffer to drain. It answers with an active-low hold acknowledge only after the buffer reports empty while posting is disabled. A posted write can then never wait behind a bus that the agent owns while the agent waits on ISA traffic, so no PCI-to-ISA deadlock can form.

When the agent releases its request, the acknowledge drops on the next clock. Posting is re-enabled one clock after that. If the agent withdraws its request before it has been granted, the controller drops the sequence, re-enables posting and waits for the next request. The write buffer and the PCI arbiter sit outside this block. The controller only sees the buffer's empty flag and drives the flush and post-disable controls.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, hold_ack_n is 1, flush_req is 0 and post_dis is 0.
- R2: A hold_req_n of 0 sampled at a clock edge while idle makes post_dis 1 after that edge, and post_dis stays 1 until the sequence ends.
- R3: flush_req is 1 from the first edge after the request until the grant edge. It is 0 while the acknowledge is asserted and whenever post_dis is 0.
- R4: hold_ack_n goes to 0 only at an edge where the request is still 0 and buf_empty is 1, and no earlier than the third edge after the request is first sampled. This holds even when buf_empty is already 1 at the request.
- R5: While buf_empty stays 0, hold_ack_n stays 1 however long the request is held.
- R6: Once granted, hold_ack_n stays 0 at every edge where hold_req_n is sampled 0.
- R7: The first edge that samples hold_req_n as 1 during a grant sets hold_ack_n to 1. post_dis is still 1 after that edge.
- R8: One edge after hold_ack_n returns to 1, post_dis goes to 0 and the controller is idle.
- R9: If hold_req_n is sampled 1 before the grant, the next state is idle: post_dis and flush_req go to 0 after that edge, and hold_ack_n never goes to 0 for that request.
- R10: While idle with hold_req_n at 1, buf_empty has no effect: all three outputs stay at their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_n | input | 1 | Bus hold request from the agent, active low |
| buf_empty | input | 1 | Posted write buffer holds no entries |
| hold_ack_n | output | 1 | Bus hold acknowledge to the agent, active low |
| flush_req | output | 1 | Asks the posted write buffer to drain |
| post_dis | output | 1 | Blocks new CPU-to-PCI writes from being posted |

## Verification
The bench sweeps every pairing of the edge at which the buffer reports empty (including already empty at the request) with the edge at which the agent lets go (including before, at and after the grant). For each pairing it predicts all three outputs edge by edge from simple arithmetic. Three kinds of faulty design would show up. One that grants as soon as the buffer is empty would acknowledge before posting was disabled for a full step. One that abandons wrongly would either leave posting disabled or flash the acknowledge after an early withdrawal. One that clears post_dis together with the acknowledge would let writes post while the agent still holds the bus. Idle stretches with the empty flag toggling confirm that it alone starts nothing.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLUSH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_GRANT = 3'd3,
        ST_REL   = 3'd4
    } bhc_state_e;

    typedef struct packed {
        logic ack;       // active-high internal form of the acknowledge
        logic flush;
        logic post_dis;
    } bhc_drive_t;

    function automatic bhc_drive_t bhc_decode(input bhc_state_e st);
        bhc_drive_t d;
        d = '0;
        case (st)
            ST_FLUSH, ST_WAIT: begin
                d.flush    = 1'b1;
                d.post_dis = 1'b1;
            end
            ST_GRANT: begin
                d.ack      = 1'b1;
                d.post_dis = 1'b1;
            end
            ST_REL:   d.post_dis = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bhc_seq_fsm.sv
module bhc_seq_fsm
    import bhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       empty,
    output bhc_state_e state
);

    bhc_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (req) nxt = ST_FLUSH;
            ST_FLUSH: nxt = req ? ST_WAIT : ST_IDLE;
            ST_WAIT: begin
                if (!req)       nxt = ST_IDLE;
                else if (empty) nxt = ST_GRANT;
            end
            ST_GRANT: if (!req) nxt = ST_REL;
            ST_REL:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R4: the grant state is entered only from the wait state with the request held
    assert_grant_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_GRANT) ##1 (state == ST_GRANT) |-> $past(req && empty));

    // R9: a withdrawn request before the grant returns to idle
    assert_abandon_R9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FLUSH || state == ST_WAIT) && !req) |=> (state == ST_IDLE));

endmodule

// File: rtl/bhc_pin_drive.sv
module bhc_pin_drive
    import bhc_pkg::*;
(
    input  bhc_state_e state,
    output logic       hold_ack_n,
    output logic       flush_req,
    output logic       post_dis
);

    bhc_drive_t drv;

    always_comb begin
        drv        = bhc_decode(state);
        hold_ack_n = ~drv.ack;
        flush_req  = drv.flush;
        post_dis   = drv.post_dis;
    end

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bhc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_req_n,
    input  logic buf_empty,
    output logic hold_ack_n,
    output logic flush_req,
    output logic post_dis
);

    bhc_state_e state;
    logic       req;

    assign req = ~hold_req_n;

    bhc_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .empty (buf_empty),
        .state (state)
    );

    bhc_pin_drive u_drv (
        .state      (state),
        .hold_ack_n (hold_ack_n),
        .flush_req  (flush_req),
        .post_dis   (post_dis)
    );

    // R4: an acknowledge only ever stands with posting disabled
    assert_ack_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> post_dis);

    // R4: the acknowledge falls only after an empty buffer seen under disable
    assert_ack_after_empty_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> $past(post_dis && buf_empty && !hold_req_n));

    // R3: flushing happens only with posting blocked and never during a grant
    assert_flush_scope_R3: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (post_dis && hold_ack_n));

    // R6: grant held while the request is held
    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_n && !hold_req_n) |=> !hold_ack_n);

    // R7: release of the request drops the acknowledge next clock
    assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
        (!hold_ack_n && hold_req_n) |=> (hold_ack_n && post_dis));

    // R8: posting returns one clock after the acknowledge deasserts
    assert_post_reenable_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |=> !post_dis);

endmodule

// File: tb/sim_bus_hold_ctrl.sv
`timescale 1ns/1ps
module sim_bus_hold_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req_n = 1'b1;
    logic buf_empty = 1'b0;
    logic hold_ack_n, flush_req, post_dis;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bus_hold_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .hold_req_n (hold_req_n),
        .buf_empty  (buf_empty),
        .hold_ack_n (hold_ack_n),
        .flush_req  (flush_req),
        .post_dis   (post_dis)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "hold_ack_n", hold_ack_n, 1'b1);
        chk(tag, "flush_req",  flush_req,  1'b0);
        chk(tag, "post_dis",   post_dis,   1'b0);
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        #1;
        chk_idle("R1");
        edge_step();
        edge_step();
        chk_idle("R1");
        rst = 1'b0;
        edge_step();
        chk_idle("R1");

        // R10: empty flag toggling while idle starts nothing
        for (int i = 0; i < 4; i++) begin
            buf_empty = i[0];
            edge_step();
            chk_idle("R10");
        end

        // Sweep: empty from edge E on, request low for edges 1..R
        for (int e = 0; e <= 6; e++) begin
            for (int r = 1; r <= 9; r++) begin
                int g;
                bit granted;
                g = (e > 3) ? e : 3;
                granted = (r >= g);
                for (int k = 1; k <= r + 3; k++) begin
                    logic ea, ef, ep;
                    string ta, tf, tp;
                    hold_req_n = (k <= r) ? 1'b0 : 1'b1;
                    buf_empty  = (k >= e) ? 1'b1 : 1'b0;
                    edge_step();
                    if (granted) begin
                        ea = !(k >= g && k <= r);
                        ef = (k >= 1 && k < g);
                        ep = (k >= 1 && k <= r + 1);
                        if (k < g)       ta = (e > 3) ? "R5" : "R4";
                        else if (k == g) ta = "R4";
                        else if (k <= r) ta = "R6";
                        else             ta = "R7";
                        tf = "R3";
                        if (k <= r)          tp = "R2";
                        else if (k == r + 1) tp = "R7";
                        else                 tp = "R8";
                    end else begin
                        ea = 1'b1;
                        ef = (k >= 1 && k <= r);
                        ep = (k >= 1 && k <= r);
                        ta = "R9";
                        tf = (k <= r) ? "R3" : "R9";
                        tp = (k <= r) ? "R2" : "R9";
                    end
                    chk(ta, "hold_ack_n", hold_ack_n, ea);
                    chk(tf, "flush_req",  flush_req,  ef);
                    chk(tp, "post_dis",   post_dis,   ep);
                end
                // R10: idle with buffer empty and request high
                buf_empty = 1'b1;
                edge_step();
                chk_idle("R10");
                buf_empty = 1'b0;
            end
        end

        // R5: long wait with the buffer never empty
        hold_req_n = 1'b0;
        buf_empty  = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            edge_step();
            chk("R5", "hold_ack_n", hold_ack_n, 1'b1);
            chk("R2", "post_dis",   post_dis,   1'b1);
        end
        buf_empty = 1'b1;
        edge_step();
        chk("R4", "hold_ack_n", hold_ack_n, 1'b0);
        chk("R3", "flush_req",  flush_req,  1'b0);
        hold_req_n = 1'b1;
        edge_step();
        chk("R7", "hold_ack_n", hold_ack_n, 1'b1);
        chk("R7", "post_dis",   post_dis,   1'b1);
        // R8: a new request during the release step waits for idle
        hold_req_n = 1'b0;
        edge_step();
        chk("R8", "post_dis", post_dis, 1'b0);
        edge_step();
        chk("R2", "post_dis", post_dis, 1'b1);
        chk("R4", "hold_ack_n", hold_ack_n, 1'b1);
        edge_step();
        chk("R4", "hold_ack_n", hold_ack_n, 1'b1);
        edge_step();
        chk("R4", "hold_ack_n", hold_ack_n, 1'b0);
        hold_req_n = 1'b1;
        edge_step();
        edge_step();
        chk_idle("R8");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule